// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects five interrupt sources: two external active-low pins, two timer overflow flags and a serial flag formed from the OR of a receive flag and a transmit flag. It selects one of them and presents it to a processor core as a request together with a 16-bit vector address. Software sets it up through a small write port that holds three registers. The first is an enable register with one bit per source and a global gate bit. The second is a priority register that puts each source in the high or the low level. The third is a trigger register that sets each external pin to level or falling-edge operation.

A sequencer with three states, SEQ_IDLE, SEQ_PEND and SEQ_GRANT, runs the handshake with the core:

- **raise** (SEQ_IDLE to SEQ_PEND): an eligible winner exists.
- **repoll** (SEQ_PEND to SEQ_PEND): with no acknowledge, the held winner is reloaded from the current arbitration.
- **withdraw** (SEQ_PEND to SEQ_IDLE): no source is eligible any more.
- **accept** (SEQ_PEND to SEQ_GRANT): the core acknowledges. The in-service flag of the granted level is set, an edge latch is consumed, or a timer clear strobe is issued.
- **finish** (SEQ_GRANT to SEQ_IDLE): always taken after one cycle.

Two in-service flags, one per level, decide which requests may preempt a running handler. A return strobe from the core clears the higher of the two flags that is set.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all three registers are zero, so no request is raised even when every source is active. After reset `irq_req`, `irq_vector`, `in_service` and `tmr_clr` are all zero.
- R2: The write port uses these addresses:
    - Address 0 is the enable register. Bits 4..0 are the per-source enables and bit 7 is the global gate.
    - Address 1 is the priority register. Bits 4..0 select the level for each source, where 1 means the high level.
    - Address 2 is the trigger register. Bit 0 is for external 0 and bit 1 is for external 1, where 1 means edge and 0 means level.
    - Source bit order in all registers is external 0, timer 0, external 1, timer 1, serial.
- R3: A request is raised only when the source's enable bit is 1 and the global gate is 1.
- R4: Among eligible sources in the same level, the lowest bit index wins: external 0, then timer 0, then external 1, then timer 1, then serial.
- R5: An eligible high-level source always wins over any low-level source. Priority bits may be rewritten at any time and take effect on the next arbitration.
- R6: While a low-level handler is in service, only high-level sources may raise a request. While a high-level handler is in service, no request is raised.
- R7: The vector is 0x0003 plus 8 times the winner's bit index, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. The vector reads 0 whenever `irq_req` is low.
- R8: An acknowledge while `irq_req` is high sets the in-service bit of the granted level. In `in_service`, bit 1 is the high level and bit 0 is the low level. A return strobe clears bit 1 if it is set, and otherwise clears bit 0.
- R9: In edge mode, a synchronized high-to-low transition on a pin latches a pending request. The request stays pending after the pin returns high, and it is cleared only when its vector is acknowledged. A pin held low does not request again.
- R10: In level mode, a pin held low requests, a pin that is high does not, and a pin still low after its handler returns requests again.
- R11: Acknowledging timer 0 or timer 1 produces a one-cycle strobe on `tmr_clr` bit 0 or bit 1, in the cycle after the acknowledge. A serial grant produces no strobe, so a serial flag that is still set requests again after the return.
- R12: If the pending source loses eligibility before it is acknowledged, `irq_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 enable, 1 priority, 2 trigger |
| cfg_wdata | input | 8 | Register write data |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| ext0_n | input | 1 | External pin 0, active low |
| ext1_n | input | 1 | External pin 1, active low |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 16 | Vector address of the pending source |
| in_service | output | 2 | In-service flags, bit 1 high level, bit 0 low level |
| tmr_clr | output | 2 | One-cycle clear strobes for the timer flags |

## Verification
On every cycle, the assertions check these properties:

- Any winner is an enabled pending source.
- A low-level winner never shadows an enabled high-level one, and nothing is raised while the high level is in service.
- An accept sets the matching in-service bit, and a return clears the high bit.
- A timer clear strobe follows an accept.
- Edge latches set on a synchronized fall and stay empty in level mode.

Only the bench scenarios can show several things:

- The exact ordering over every mix of pending sources and priority settings.
- The vector values themselves.
- Preemption across a chain of acknowledges and returns.
- The difference between an edge pin and a level pin held low after a handler returns.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int NUM_SRC    = 5;
    localparam int SRC_IDX_W  = $clog2(NUM_SRC);
    localparam int NUM_EXT    = 2;
    localparam int NUM_TMR    = 2;
    localparam int NUM_LVL    = 2;
    localparam int LVL_LO     = 0;
    localparam int LVL_HI     = 1;
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;

    // register addresses on the write port
    localparam int CFG_ENABLE = 0;
    localparam int CFG_PRIO   = 1;
    localparam int CFG_MODE   = 2;

    typedef logic [SRC_IDX_W-1:0] src_idx_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PEND  = 2'd1,
        SEQ_GRANT = 2'd2
    } seq_state_e;

    // external pin e sits at source index 2e, timer t at 2t+1
    function automatic int ext_src(input int e);
        return 2 * e;
    endfunction

    function automatic int tmr_src(input int t);
        return 2 * t + 1;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input src_idx_t idx);
        return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_SRC-1:0] src_en,
    output logic               glob_en,
    output logic [NUM_SRC-1:0] prio,
    output logic [NUM_EXT-1:0] edge_mode
);
    localparam int GLOBAL_BIT = DATA_W - 1;

    logic cfg_unused;
    assign cfg_unused = ^wr_data[GLOBAL_BIT-1:NUM_SRC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en    <= '0;
            glob_en   <= 1'b0;
            prio      <= '0;
            edge_mode <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(CFG_ENABLE): begin
                    src_en  <= wr_data[NUM_SRC-1:0];
                    glob_en <= wr_data[GLOBAL_BIT];
                end
                ADDR_W'(CFG_PRIO): prio      <= wr_data[NUM_SRC-1:0];
                ADDR_W'(CFG_MODE): edge_mode <= wr_data[NUM_EXT-1:0];
                default: ;
            endcase
        end
    end

    // R2: a write to an address leaves the other registers untouched
    a_r2_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr != ADDR_W'(CFG_PRIO)) |=> $stable(prio));
endmodule

// File: rtl/irq_ext_trig.sv
module irq_ext_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   latch_q;
    logic                   latch_d;
    logic                   synced;
    logic                   fall;

    assign synced = sync_q[SYNC_STAGES-1];
    assign fall   = prev_q & ~synced;

    always_comb begin
        if (!edge_mode)  latch_d = 1'b0;
        else if (fall)   latch_d = 1'b1;
        else if (clr)    latch_d = 1'b0;
        else             latch_d = latch_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '1;
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], pin_n};
            prev_q  <= synced;
            latch_q <= latch_d;
        end
    end

    assign req = edge_mode ? latch_q : ~synced;

    // R9: a synchronized fall in edge mode leaves a pending latch
    a_r9_fall_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $fell(synced)) |=> latch_q);

    // R9: without a fall, only a grant empties the latch
    a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && latch_q && !clr) |=> (latch_q || !$past(edge_mode) || !edge_mode));

    // R10: level mode never keeps a latched edge
    a_r10_level_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> !latch_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glob_en,
    input  logic [NUM_SRC-1:0] prio,
    input  logic               isr_hi,
    input  logic               isr_lo,
    output logic               win_valid,
    output src_idx_t           win_idx,
    output logic               win_hi
);
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] hi_set;
    logic [NUM_SRC-1:0] lo_set;

    function automatic src_idx_t first_set(input logic [NUM_SRC-1:0] v);
        src_idx_t r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = src_idx_t'(i);
        end
        return r;
    endfunction

    always_comb begin
        elig      = pend & src_en & {NUM_SRC{glob_en}};
        hi_set    = elig & prio;
        lo_set    = elig & ~prio;
        win_valid = 1'b0;
        win_hi    = 1'b0;
        win_idx   = '0;
        if (!isr_hi && (|hi_set)) begin
            win_valid = 1'b1;
            win_hi    = 1'b1;
            win_idx   = first_set(hi_set);
        end else if (!isr_hi && !isr_lo && (|lo_set)) begin
            win_valid = 1'b1;
            win_idx   = first_set(lo_set);
        end
    end

    // R3: a winner is always an enabled, pending source behind the gate
    a_r3_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (glob_en && pend[win_idx] && src_en[win_idx]));

    // R5: a low-level winner means no enabled high-level source is pending
    a_r5_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_hi) |-> ((pend & src_en & prio) == '0));

    // R6: nothing is chosen while the high level is in service
    a_r6_hi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        isr_hi |-> !win_valid);

    // R6: a low-level winner needs both levels idle
    a_r6_lo_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_hi) |-> !isr_lo);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_valid,
    input  src_idx_t           win_idx,
    input  logic               win_hi,
    input  logic               ack,
    input  logic               reti,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [NUM_LVL-1:0] in_service,
    output logic               accept,
    output src_idx_t           src_q,
    output logic [NUM_TMR-1:0] tmr_clr
);
    seq_state_e         state_q;
    seq_state_e         state_d;
    logic               load;
    logic               lvl_q;
    logic [NUM_LVL-1:0] isr_q;
    logic [NUM_LVL-1:0] isr_d;

    // next state: raise, repoll, withdraw, accept, finish
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (win_valid) begin
                    state_d = SEQ_PEND;
                    load    = 1'b1;
                end
            end
            SEQ_PEND: begin
                if (ack) begin
                    state_d = SEQ_GRANT;
                end else if (!win_valid) begin
                    state_d = SEQ_IDLE;
                end else begin
                    load = 1'b1;
                end
            end
            SEQ_GRANT: state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        isr_d = isr_q;
        if (reti) begin
            if (isr_q[LVL_HI]) isr_d[LVL_HI] = 1'b0;
            else               isr_d[LVL_LO] = 1'b0;
        end
        if (accept) isr_d[lvl_q] = 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            src_q   <= '0;
            lvl_q   <= 1'b0;
            isr_q   <= '0;
        end else begin
            state_q <= state_d;
            isr_q   <= isr_d;
            if (load) begin
                src_q <= win_idx;
                lvl_q <= win_hi;
            end
        end
    end

    // outputs
    always_comb begin
        irq_req    = (state_q == SEQ_PEND);
        accept     = (state_q == SEQ_PEND) && ack;
        irq_vector = (state_q == SEQ_PEND) ? vec_of(src_q) : '0;
        in_service = isr_q;
        for (int t = 0; t < NUM_TMR; t++) begin
            tmr_clr[t] = (state_q == SEQ_GRANT) && (src_q == src_idx_t'(tmr_src(t)));
        end
    end

    // R6: a request never rises while the high level is in service
    a_r6_no_raise_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !$past(isr_q[LVL_HI]));

    // R8: an accepted high-level vector marks the high level busy
    a_r8_accept_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lvl_q) |=> isr_q[LVL_HI]);

    // R8: an accepted low-level vector marks the low level busy
    a_r8_accept_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lvl_q) |=> isr_q[LVL_LO]);

    // R8: a return with the high level busy frees it
    a_r8_reti_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && isr_q[LVL_HI] && !(accept && lvl_q)) |=> !isr_q[LVL_HI]);

    // R11: a timer clear strobe only follows an accept
    a_r11_clr_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_clr) |-> $past(accept));

    // R12: a pending request with no eligible source and no ack is withdrawn
    a_r12_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !win_valid && !ack) |=> !irq_req);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               tmr0_ovf,
    input  logic               tmr1_ovf,
    input  logic               ext0_n,
    input  logic               ext1_n,
    input  logic               ser_rx_flag,
    input  logic               ser_tx_flag,
    input  logic               irq_ack,
    input  logic               irq_reti,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [NUM_LVL-1:0] in_service,
    output logic [NUM_TMR-1:0] tmr_clr
);
    logic [NUM_SRC-1:0] src_en;
    logic               glob_en;
    logic [NUM_SRC-1:0] prio;
    logic [NUM_EXT-1:0] edge_mode;
    logic [NUM_EXT-1:0] ext_pin_n;
    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_TMR-1:0] tmr_flag;
    logic [NUM_SRC-1:0] pend;
    logic               win_valid;
    src_idx_t           win_idx;
    logic               win_hi;
    logic               accept;
    src_idx_t           src_q;

    assign ext_pin_n = {ext1_n, ext0_n};
    assign tmr_flag  = {tmr1_ovf, tmr0_ovf};

    irq_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .src_en    (src_en),
        .glob_en   (glob_en),
        .prio      (prio),
        .edge_mode (edge_mode)
    );

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        irq_ext_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[e]),
            .edge_mode (edge_mode[e]),
            .clr       (accept && (src_q == src_idx_t'(ext_src(e)))),
            .req       (ext_req[e])
        );
        assign pend[ext_src(e)] = ext_req[e];
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        assign pend[tmr_src(t)] = tmr_flag[t];
    end

    assign pend[NUM_SRC-1] = ser_rx_flag | ser_tx_flag;

    irq_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .src_en    (src_en),
        .glob_en   (glob_en),
        .prio      (prio),
        .isr_hi    (in_service[LVL_HI]),
        .isr_lo    (in_service[LVL_LO]),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_hi    (win_hi)
    );

    irq_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_hi     (win_hi),
        .ack        (irq_ack),
        .reti       (irq_reti),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .in_service (in_service),
        .accept     (accept),
        .src_q      (src_q),
        .tmr_clr    (tmr_clr)
    );

    // R3: a new request only rises when the global gate was open
    a_r3_raise_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(glob_en));

    // R7: the vector is zero whenever no request is shown
    a_r7_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vector == '0));
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
    logic        ext0_n = 1'b1, ext1_n = 1'b1;
    logic        ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
    logic        irq_ack = 1'b0, irq_reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vector;
    logic [1:0]  in_service;
    logic [1:0]  tmr_clr;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .ext0_n(ext0_n), .ext1_n(ext1_n), .ser_rx_flag(ser_rx_flag),
        .ser_tx_flag(ser_tx_flag), .irq_ack(irq_ack), .irq_reti(irq_reti),
        .irq_req(irq_req), .irq_vector(irq_vector), .in_service(in_service),
        .tmr_clr(tmr_clr)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_wr = 1'b0;
    endtask

    // bit order: ext0, tmr0, ext1, tmr1, serial
    task automatic drive(input logic [4:0] p, input bit use_tx);
        ext0_n      = ~p[0];
        tmr0_ovf    = p[1];
        ext1_n      = ~p[2];
        tmr1_ovf    = p[3];
        ser_rx_flag = p[4] & ~use_tx;
        ser_tx_flag = p[4] & use_tx;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    endtask

    task automatic reti_once();
        irq_reti = 1'b1; step(1); irq_reti = 1'b0;
    endtask

    function automatic int low_idx(input logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [15:0] vec_exp(input int idx);
        return 16'(3 + 8 * idx);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        chk("R1 irq_req", 32'(irq_req), 0);
        chk("R1 vector", 32'(irq_vector), 0);
        chk("R1 in_service", 32'(in_service), 0);
        chk("R1 tmr_clr", 32'(tmr_clr), 0);
        drive(5'h1F, 1'b0); step(6);
        chk("R1 disabled after reset", 32'(irq_req), 0);
        drive(5'h00, 1'b0); step(6);

        // R3: enable sweep, all sources active, all low level
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        for (int en = 0; en < 32; en++) begin
            wr(2'd0, 8'h80 | 8'(en));
            drive(5'h1F, en[0]); step(6);
            chk("R3 req with enables", 32'(irq_req), 32'(en != 0));
            chk("R2 R7 vector under enables", 32'(irq_vector),
                (en != 0) ? 32'(vec_exp(low_idx(5'(en)))) : 0);
            drive(5'h00, 1'b0); step(6);
        end
        wr(2'd0, 8'h1F);
        drive(5'h1F, 1'b0); step(6);
        chk("R3 global gate closed", 32'(irq_req), 0);
        drive(5'h00, 1'b0); step(6);

        // R4 R5 R7 R12: every pending mix under every priority setting
        wr(2'd0, 8'h9F);
        for (int pr = 0; pr < 32; pr++) begin
            wr(2'd1, 8'(pr));
            for (int p = 1; p < 32; p++) begin
                logic [4:0] hi;
                int         w;
                hi = 5'(p) & 5'(pr);
                w  = (hi != 0) ? low_idx(hi) : low_idx(5'(p));
                drive(5'(p), pr[1]); step(6);
                chk("R4 R5 req", 32'(irq_req), 1);
                chk("R4 R5 R7 vector", 32'(irq_vector), 32'(vec_exp(w)));
                drive(5'h00, 1'b0); step(6);
                chk("R12 withdraw", 32'(irq_req), 0);
            end
        end

        // R6 R8 R11: preemption chain, level mode
        wr(2'd1, 8'h08);
        tmr0_ovf = 1'b1; step(3);
        chk("R7 timer0 vector", 32'(irq_vector), 32'h0B);
        ack_once();
        chk("R8 low in service", 32'(in_service), 2'b01);
        chk("R11 timer0 clear strobe", 32'(tmr_clr), 2'b01);
        chk("R8 req drops on grant", 32'(irq_req), 0);
        tmr0_ovf = 1'b0; step(1);
        chk("R11 strobe one cycle", 32'(tmr_clr), 0);
        ext0_n = 1'b0; step(6);
        chk("R6 low blocked by low", 32'(irq_req), 0);
        tmr1_ovf = 1'b1; step(3);
        chk("R6 high preempts low", 32'(irq_vector), 32'h1B);
        ack_once();
        chk("R8 both in service", 32'(in_service), 2'b11);
        chk("R11 timer1 clear strobe", 32'(tmr_clr), 2'b10);
        tmr1_ovf = 1'b0;
        wr(2'd1, 8'h18);
        ser_tx_flag = 1'b1; step(6);
        chk("R6 nothing preempts high", 32'(irq_req), 0);
        reti_once();
        chk("R8 reti clears high first", 32'(in_service), 2'b01);
        step(2);
        chk("R5 runtime priority serial", 32'(irq_vector), 32'h23);
        ack_once();
        chk("R8 serial grant high", 32'(in_service), 2'b11);
        chk("R11 serial no strobe", 32'(tmr_clr), 0);
        reti_once(); step(2);
        chk("R11 serial re-requests", 32'(irq_vector), 32'h23);
        ser_tx_flag = 1'b0; step(2);
        chk("R12 serial withdrawn", 32'(irq_req), 0);
        reti_once();
        chk("R8 reti clears low", 32'(in_service), 2'b00);
        step(5);
        chk("R10 level pin requests", 32'(irq_vector), 32'h03);
        ack_once(); reti_once(); step(5);
        chk("R10 level pin requests again", 32'(irq_vector), 32'h03);
        ext0_n = 1'b1; step(6);
        chk("R10 high pin no request", 32'(irq_req), 0);

        // R9: edge mode
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);
        ext0_n = 1'b0; step(3); ext0_n = 1'b1; step(6);
        chk("R9 edge held after pin high", 32'(irq_vector), 32'h03);
        ack_once(); reti_once(); step(6);
        chk("R9 latch cleared on grant", 32'(irq_req), 0);
        ext0_n = 1'b0; step(6);
        chk("R9 edge on held pin", 32'(irq_vector), 32'h03);
        ack_once(); reti_once(); step(6);
        chk("R9 held low no repeat", 32'(irq_req), 0);
        ext0_n = 1'b1;
        wr(2'd2, 8'h02);
        ext1_n = 1'b0; step(2); ext1_n = 1'b1; step(6);
        chk("R9 edge on pin 1", 32'(irq_vector), 32'h13);
        ack_once(); reti_once(); step(6);
        chk("R9 pin 1 latch cleared", 32'(irq_req), 0);
        chk("R8 idle at end", 32'(in_service), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule